// File: doc/BRIEF.md
# SPI Burst Serializer

This block is the transfer engine of an SPI master working in mode 0. A single start strobe launches one burst. The burst length comes from a length input that holds N, and the burst is N+1 bits long. The engine pulls 32-bit words from a transmit FIFO over a valid/ready port and shifts their bits out on MOSI. At the same time it samples MISO and packs those bits into words that it writes to a receive FIFO. One active-low chip select frames the whole burst, even when the burst spans several FIFO words.

A burst that is not a whole number of words is split with the leftover bits first. The first word supplies only the (N+1) mod 32 bits at its low end, or all 32 bits when that remainder is zero. Every later word supplies all 32 bits. Within a word, the active bits go out from the most significant active bit downward, so earlier bytes come from higher positions. Each received word holds as many bits as its transmit word sent, right-aligned, with the first bit received in the most significant of those positions.

If the transmit FIFO runs dry in the middle of a burst, or the receive FIFO is full when a word boundary is reached, the engine waits with SCLK low and chip select still asserted. A busy output covers the whole frame, and a one-cycle done pulse marks the end of the burst.

Top module: `spi_burst_master`

## Requirements
- R1: A burst started with `burst_len` = N produces exactly N+1 rising SCLK edges, and no further edges until the next start.
- R2: A burst consumes ceil((N+1)/32) transmit words. The first word supplies (N+1) mod 32 bits, or 32 bits when that remainder is 0. Every later word supplies 32 bits.
- R3: For each word that supplies k bits, MOSI carries word bit k-1 first and bit 0 last. Bits above k-1 of a partial first word are never sent.
- R4: One receive word is written for each transmit word, pulsing `rx_valid` for one cycle. It holds the k bits sampled during that word in bits k-1..0, with the first sampled bit at bit k-1 and zeros above.
- R5: SCLK idles low. Each SCLK high phase lasts `half_div`+1 clock cycles. MOSI changes only after a falling SCLK edge. MISO is sampled at the rising edge.
- R6: `cs_n` falls on start and stays low across every word of the burst. It rises exactly 2*(`half_div`+1) clock cycles after the last falling SCLK edge.
- R7: If the transmit FIFO is empty, or `rx_full` is high, when a word is due to be fetched, SCLK stays low, `cs_n` stays low, no word is popped, and shifting resumes once the condition clears.
- R8: `busy` rises the cycle after an accepted start and stays high until `cs_n` rises. `done` pulses for exactly one cycle, in the cycle in which `cs_n` returns high.
- R9: While `rst_n` is low at a clock edge, the engine returns to idle: `cs_n`=1, `sclk`=0, `busy`=0, `done`=0, `tx_ready`=0 and `rx_valid`=0.
- R10: A start pulse while `busy` is high has no effect: the running burst keeps its length, and no extra burst follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle strobe that launches a burst when idle |
| burst_len | input | LEN_W | Burst length minus one, sampled at start |
| half_div | input | DIV_W | SCLK half period, in clock cycles, minus one |
| tx_data | input | WORD_W | Head word of the transmit FIFO |
| tx_valid | input | 1 | Transmit FIFO holds a word |
| tx_ready | output | 1 | Engine pops the head word in this cycle when tx_valid is high |
| rx_data | output | WORD_W | Captured receive word |
| rx_valid | output | 1 | One-cycle write strobe for the receive FIFO |
| rx_full | input | 1 | Receive FIFO has no space |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-burst pulse |

## Verification
The bench targets burst lengths with remainders of 16, 1, 8 and 0 bits modulo 32, plus a single-bit burst. A design that fills a full word first and sends the remainder last would put the wrong bits on MOSI and return receive words of the wrong width. It also targets byte and bit order within a partial word, where an engine that starts from bit 31 would send bits that must never leave. Transmit starvation mid-burst and a full receive FIFO at a word boundary are both forced: an engine that ignored either would keep clocking or pop a word too early. A start pulse in mid-burst is also tried, which would restart or extend a careless frame, and the gap from the last falling edge to chip-select release is measured at several divider settings.

// File: rtl/spi_burst_pkg.sv
// Shared types for the SPI burst serializer.
// Assumes: nothing beyond being compiled ahead of its users.
package spi_burst_pkg;

    // Engine sequencing: wait for a word, drive a bit low phase, high phase,
    // and hold chip select for the release gap.
    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_FETCH,
        ENG_LOW,
        ENG_HIGH,
        ENG_TAIL
    } eng_state_t;

endpackage

// File: rtl/spi_sclk_divider.sv
// Half-period tick generator for the serial clock.
// Counts clock cycles while run is high and issues one tick every
// half_div+1 cycles; the count restarts from zero whenever run drops.
// Assumes: half_div may change only while run is low.
module spi_sclk_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);

    logic [DIV_W-1:0] count_q;

    assign tick = run && (count_q >= half_div);

    // Advance the half-period counter, restarting on tick or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (!run || tick) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/spi_word_sizer.sv
// Decides how many bits the next FIFO word contributes to the burst.
// With the remaining bit count R, a word supplies R mod WORD_W bits, or a
// full word when that is zero; this yields the short word first and full
// words after it.
// Assumes: WORD_W is a power of two; only the low index bits of R are given.
module spi_word_sizer #(
    parameter int WORD_W = 32,
    parameter int IDX_W  = 5,
    parameter int BITS_W = 6
) (
    input  logic [IDX_W-1:0]  rem_low,
    output logic [BITS_W-1:0] word_bits
);

    // Map a zero remainder to a full word, else use the remainder itself.
    always_comb begin
        if (rem_low == '0) begin
            word_bits = BITS_W'(WORD_W);
        end else begin
            word_bits = BITS_W'(rem_low);
        end
    end

endmodule

// File: rtl/spi_shift_pair.sv
// Transmit and receive shift registers for one FIFO word.
// On load the k active bits of the word are left-aligned so that bit k-1
// leaves first; the receive register clears and then gathers sampled bits
// from its low end, leaving them right-aligned with the first bit highest.
// Assumes: load, sample and advance are never high in the same cycle.
module spi_shift_pair #(
    parameter int WORD_W = 32,
    parameter int BITS_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic [BITS_W-1:0] word_bits,
    input  logic              sample,
    input  logic              serial_in,
    input  logic              advance,
    output logic              serial_out,
    output logic [WORD_W-1:0] captured
);

    logic [WORD_W-1:0] tx_q;
    logic [WORD_W-1:0] rx_q;
    logic [BITS_W-1:0] pad;

    assign pad        = BITS_W'(WORD_W) - word_bits;
    assign serial_out = tx_q[WORD_W-1];
    assign captured   = rx_q;

    // Load a fresh word or shift the transmit side one place.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= word_in << pad;
        end else if (advance) begin
            tx_q <= {tx_q[WORD_W-2:0], 1'b0};
        end
    end

    // Clear on load, then gather sampled bits from the low end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (load) begin
            rx_q <= '0;
        end else if (sample) begin
            rx_q <= {rx_q[WORD_W-2:0], serial_in};
        end
    end

endmodule

// File: rtl/spi_burst_master.sv
// SPI mode 0 master burst engine.
// A start strobe loads burst_len+1 as the remaining bit count and asserts
// chip select. For each word, the engine waits until the transmit FIFO
// has a word and the receive FIFO has room, pops the word, and clocks out
// its active bits. It then writes the captured word. After the last bit it
// holds chip select for one SCLK period, releases it and pulses done.
// Assumes: the receive FIFO cannot become full between the fetch of a word
// and its write-back, since only this engine fills it.
module spi_burst_master
    import spi_burst_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 12,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  burst_len,
    input  logic [DIV_W-1:0]  half_div,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_full,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n,
    output logic              busy,
    output logic              done
);

    localparam int REM_W  = LEN_W + 1;
    localparam int IDX_W  = $clog2(WORD_W);
    localparam int BITS_W = $clog2(WORD_W + 1);

    eng_state_t        state_q;
    logic [REM_W-1:0]  rem_q;
    logic [BITS_W-1:0] bitcnt_q;
    logic              tail_half_q;
    logic              done_q;
    logic              rx_valid_q;

    logic              run;
    logic              tick;
    logic              load;
    logic              sample;
    logic              advance;
    logic              last_bit;
    logic              serial_out;
    logic [BITS_W-1:0] word_bits;

    // Status decodes taken straight from the sequencing state.
    assign run      = (state_q == ENG_LOW) || (state_q == ENG_HIGH) || (state_q == ENG_TAIL);
    assign last_bit = (bitcnt_q == BITS_W'(1));
    assign tx_ready = (state_q == ENG_FETCH) && !rx_full;
    assign load     = tx_ready && tx_valid;
    assign sample   = (state_q == ENG_LOW) && tick;
    assign advance  = (state_q == ENG_HIGH) && tick && !last_bit;

    assign sclk     = (state_q == ENG_HIGH);
    assign mosi     = ((state_q == ENG_LOW) || (state_q == ENG_HIGH)) ? serial_out : 1'b0;
    assign cs_n     = (state_q == ENG_IDLE);
    assign busy     = (state_q != ENG_IDLE);
    assign done     = done_q;
    assign rx_valid = rx_valid_q;

    spi_sclk_divider #(
        .DIV_W(DIV_W)
    ) i_divider (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .half_div(half_div),
        .tick    (tick)
    );

    spi_word_sizer #(
        .WORD_W(WORD_W),
        .IDX_W (IDX_W),
        .BITS_W(BITS_W)
    ) i_sizer (
        .rem_low  (rem_q[IDX_W-1:0]),
        .word_bits(word_bits)
    );

    spi_shift_pair #(
        .WORD_W(WORD_W),
        .BITS_W(BITS_W)
    ) i_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .word_in   (tx_data),
        .word_bits (word_bits),
        .sample    (sample),
        .serial_in (miso),
        .advance   (advance),
        .serial_out(serial_out),
        .captured  (rx_data)
    );

    // Sequence fetch, low phase, high phase and release gap for each burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ENG_IDLE;
            rem_q       <= '0;
            bitcnt_q    <= '0;
            tail_half_q <= 1'b0;
            done_q      <= 1'b0;
            rx_valid_q  <= 1'b0;
        end else begin
            done_q     <= 1'b0;
            rx_valid_q <= 1'b0;
            case (state_q)
                ENG_IDLE: begin
                    if (start) begin
                        rem_q   <= {1'b0, burst_len} + REM_W'(1);
                        state_q <= ENG_FETCH;
                    end
                end
                ENG_FETCH: begin
                    if (load) begin
                        bitcnt_q <= word_bits;
                        state_q  <= ENG_LOW;
                    end
                end
                ENG_LOW: begin
                    if (tick) begin
                        state_q <= ENG_HIGH;
                    end
                end
                ENG_HIGH: begin
                    if (tick) begin
                        rem_q    <= rem_q - REM_W'(1);
                        bitcnt_q <= bitcnt_q - BITS_W'(1);
                        if (last_bit) begin
                            rx_valid_q <= 1'b1;
                            state_q    <= (rem_q == REM_W'(1)) ? ENG_TAIL : ENG_FETCH;
                        end else begin
                            state_q <= ENG_LOW;
                        end
                    end
                end
                ENG_TAIL: begin
                    if (tick) begin
                        if (tail_half_q) begin
                            tail_half_q <= 1'b0;
                            done_q      <= 1'b1;
                            state_q     <= ENG_IDLE;
                        end else begin
                            tail_half_q <= 1'b1;
                        end
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_burst_master_chk.sv
// Protocol checker for the SPI burst engine, bound onto every instance.
// Observes ports only; holds nothing of its own.
module spi_burst_master_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic tx_ready,
    input logic rx_full,
    input logic rx_valid,
    input logic sclk,
    input logic mosi,
    input logic cs_n,
    input logic busy,
    input logic done
);

    // SCLK pulses only inside a chip-select frame.
    assert_sclk_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    // MOSI holds still across a high phase.
    assert_mosi_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // A word is popped only with SCLK idle, room to receive, and inside a frame.
    assert_pop_when_idle_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (!sclk && !rx_full && !cs_n));

    // Receive writes happen between bits and inside the frame.
    assert_rx_push_framed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (!sclk && !cs_n));

    // Done lasts one cycle.
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Done coincides with the release of chip select.
    assert_done_at_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !$past(cs_n)));

    // An accepted start makes the engine busy on the next cycle.
    assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

endmodule

bind spi_burst_master spi_burst_master_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .tx_ready(tx_ready),
    .rx_full (rx_full),
    .rx_valid(rx_valid),
    .sclk    (sclk),
    .mosi    (mosi),
    .cs_n    (cs_n),
    .busy    (busy),
    .done    (done)
);

// File: tb/test_spi_burst_master.sv
// Scoreboard bench: the driver queues expected MOSI bits and receive words,
// an SPI slave model drives MISO, and monitors compare as results appear.
// Clock: 8 time units per period (125 MHz at 1 ns per unit).
module test_spi_burst_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] burst_len = '0;
    logic [7:0]  half_div = '0;
    logic [31:0] tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [31:0] rx_data;
    logic        rx_valid;
    logic        rx_full = 1'b0;
    logic        sclk;
    logic        mosi;
    logic        miso = 1'b0;
    logic        cs_n;
    logic        busy;
    logic        done;

    int total = 0;
    int bad = 0;
    int rise_cnt = 0;
    int pop_cnt = 0;
    int done_cnt = 0;
    int cur_div = 0;
    int m_idx = 0;
    int cyc = 0;
    bit armed = 1'b0;
    bit hold_tx = 1'b0;
    bit finished = 1'b0;
    logic fire = 1'b0;
    time t_rise = 0;
    time t_fall = 0;

    bit          exp_mosi[$];
    logic [31:0] exp_rx[$];
    logic [31:0] txq[$];
    bit          mbits[0:127];

    spi_burst_master i_spi_burst_master (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .burst_len(burst_len),
        .half_div (half_div),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .rx_full  (rx_full),
        .sclk     (sclk),
        .mosi     (mosi),
        .miso     (miso),
        .cs_n     (cs_n),
        .busy     (busy),
        .done     (done)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: each rising SCLK edge is one bit; compare MOSI with the queue.
    always @(posedge sclk) begin
        t_rise = $time;
        rise_cnt++;
        #1;
        if (exp_mosi.size() == 0) begin
            check(1'b0, "R1", "unexpected extra bit", 32'(rise_cnt), 32'(rise_cnt - 1));
        end else begin
            bit e;
            e = exp_mosi.pop_front();
            check(mosi === e, "R3", "mosi bit", 32'(mosi), 32'(e));
        end
    end

    // Slave: check high-phase width, then present the next MISO bit.
    always @(negedge sclk) begin
        check(($time - t_rise) == time'((cur_div + 1) * 8), "R5", "sclk high width",
              32'($time - t_rise), 32'((cur_div + 1) * 8));
        t_fall = $time;
        m_idx++;
        if (m_idx < 128) miso = mbits[m_idx];
    end

    // Slave: first MISO bit is ready as soon as chip select falls.
    always @(negedge cs_n) begin
        m_idx = 0;
        miso = mbits[0];
    end

    // Release gap: one SCLK period after the last falling edge.
    always @(posedge cs_n) begin
        if (armed) begin
            check(($time - t_fall) == time'(2 * (cur_div + 1) * 8), "R6", "cs release gap",
                  32'($time - t_fall), 32'(2 * (cur_div + 1) * 8));
        end
    end

    // Transmit FIFO model: note a pop at the edge, apply it half a cycle later.
    always @(posedge clk) fire <= tx_valid && tx_ready;

    always @(negedge clk) begin
        if (fire) begin
            void'(txq.pop_front());
            pop_cnt++;
        end
        if (done) done_cnt++;
        if (rx_valid) begin
            if (exp_rx.size() == 0) begin
                check(1'b0, "R4", "unexpected rx word", rx_data, 32'h0);
            end else begin
                logic [31:0] e;
                e = exp_rx.pop_front();
                check(rx_data === e, "R4", "rx word", rx_data, e);
            end
        end
        tx_valid = (txq.size() > 0) && !(hold_tx && pop_cnt >= 1);
        tx_data  = (txq.size() > 0) ? txq[0] : 32'h0;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Driver: build expectations for one burst, run it, check the totals.
    // mode 0 plain, 1 receive FIFO full at start, 2 transmit starvation
    // after the first word, 3 extra start pulse mid-burst.
    task automatic run_burst(input int n, input int div, input int mode);
        int bits;
        int k;
        int words;
        int idx;
        bits  = n + 1;
        k     = bits % 32;
        if (k == 0) k = 32;
        words = (bits - k) / 32 + 1;
        cur_div   = div;
        half_div  = 8'(div);
        burst_len = 12'(n);
        rise_cnt  = 0;
        pop_cnt   = 0;
        done_cnt  = 0;
        for (int i = 0; i < 128; i++) mbits[i] = ^(32'(i * 37 + n * 11 + 5));
        for (int w = 0; w < words; w++) begin
            logic [31:0] word;
            int width;
            word  = (32'h9E3779B9 * 32'(w + 3)) ^ 32'(n * 16843009);
            width = (w == 0) ? k : 32;
            txq.push_back(word);
            for (int b = width - 1; b >= 0; b--) exp_mosi.push_back(word[b]);
        end
        idx = 0;
        for (int w = 0; w < words; w++) begin
            logic [31:0] v;
            int width;
            width = (w == 0) ? k : 32;
            v = '0;
            for (int b = 0; b < width; b++) begin
                v = {v[30:0], mbits[idx]};
                idx++;
            end
            exp_rx.push_back(v);
        end
        hold_tx = (mode == 2);
        rx_full = (mode == 1);
        armed   = 1'b1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(busy === 1'b1, "R8", "busy after start", 32'(busy), 32'h1);
        check(cs_n === 1'b0, "R6", "cs low after start", 32'(cs_n), 32'h0);
        if (mode == 1) begin
            repeat (20) @(negedge clk);
            check(rise_cnt == 0, "R7", "no clock while rx full", 32'(rise_cnt), 32'h0);
            check(pop_cnt == 0, "R7", "no pop while rx full", 32'(pop_cnt), 32'h0);
            check(cs_n === 1'b0, "R7", "cs held while rx full", 32'(cs_n), 32'h0);
            rx_full = 1'b0;
        end
        if (mode == 2) begin
            wait (rise_cnt == 32);
            repeat (40) @(negedge clk);
            check(rise_cnt == 32, "R7", "no clock while tx empty", 32'(rise_cnt), 32'd32);
            check(sclk === 1'b0, "R7", "sclk idle while tx empty", 32'(sclk), 32'h0);
            check(cs_n === 1'b0, "R7", "cs held while tx empty", 32'(cs_n), 32'h0);
            hold_tx = 1'b0;
        end
        if (mode == 3) begin
            wait (rise_cnt == 10);
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        wait (done_cnt >= 1);
        repeat (6) @(negedge clk);
        check(rise_cnt == bits, "R1", "sclk edges in burst", 32'(rise_cnt), 32'(bits));
        check(pop_cnt == words, "R2", "words popped", 32'(pop_cnt), 32'(words));
        check(done_cnt == 1, "R8", "done pulses", 32'(done_cnt), 32'h1);
        check(busy === 1'b0, "R8", "busy after burst", 32'(busy), 32'h0);
        check(cs_n === 1'b1, "R6", "cs released", 32'(cs_n), 32'h1);
        check(exp_mosi.size() == 0, "R3", "mosi bits left", 32'(exp_mosi.size()), 32'h0);
        check(exp_rx.size() == 0, "R4", "rx words left", 32'(exp_rx.size()), 32'h0);
        if (mode == 3) begin
            check(rise_cnt == bits && done_cnt == 1, "R10", "start while busy ignored",
                  32'(rise_cnt), 32'(bits));
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(cs_n === 1'b1, "R9", "reset cs_n", 32'(cs_n), 32'h1);
        check(sclk === 1'b0, "R9", "reset sclk", 32'(sclk), 32'h0);
        check(busy === 1'b0 && done === 1'b0, "R9", "reset busy/done",
              32'({busy, done}), 32'h0);
        check(tx_ready === 1'b0 && rx_valid === 1'b0, "R9", "reset fifo strobes",
              32'({tx_ready, rx_valid}), 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        run_burst(47, 0, 0);   // 16 bits then 32 (R2 split order)
        run_burst(32, 1, 0);   // 1 bit then 32
        run_burst(31, 0, 0);   // exactly one full word
        run_burst(7, 2, 0);    // one byte
        run_burst(0, 0, 0);    // single bit
        run_burst(95, 1, 0);   // three full words
        run_burst(39, 3, 0);   // 8 bits then 32
        run_burst(15, 0, 1);   // receive FIFO full at first boundary
        run_burst(63, 1, 2);   // transmit FIFO empty mid-burst
        run_burst(47, 0, 3);   // start pulse while busy (R10)
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule